// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block produces the fixed answer-to-reset stream of a memory card that uses a synchronous serial interface. The host raises a reset pin, gives a clock pulse while reset is high, and drops reset. The card then drives the first response bit. Each further falling clock edge moves the stream on by one bit. The stream is 32 bits long. After the last bit the card releases the data line and goes back to standby.

The block runs on a fast system clock. The card reset pin and the card clock pin pass through a two-stage synchronizer, and edges are found from the sampled levels. A reset pulse is judged when it ends. If the clock was seen high while reset was high, the stream starts, or restarts from bit 0. If not, a stream in progress is dropped. A write-busy flag from the storage engine blocks every start. The response value is a parameter that stands in for a constant fixed at manufacture.

Top module: `atr_serializer`

## Requirements
- R1: After the system reset, `atr_oe` is 0 and `atr_data` is 1.
- R2: A card reset pulse during which the card clock was seen high, and which ends while `wr_busy` is 0, turns on `atr_oe` and drives stream bit 0 on `atr_data`.
- R3: Stream bit n is bit n of `ATR_VALUE`. Byte k sits at bits 8k+7..8k and its least significant bit is sent first. The default 32'h55AA4019 sends bytes 0x19, 0x40, 0xAA, 0x55 in that order.
- R4: While the stream is active and card reset is low, each falling card-clock edge moves `atr_data` on to the next stream bit.
- R5: The falling card-clock edge after bit 31 clears `atr_oe` and returns `atr_data` to 1.
- R6: A card reset pulse with the clock high inside it, given in the middle of a stream, restarts the stream from bit 0.
- R7: A card reset pulse with no clock high inside it aborts an active stream to standby. In standby the same pulse has no effect.
- R8: A card reset pulse that ends while `wr_busy` is 1 leaves the block in standby, even if the clock was high inside it.
- R9: Card clock pulses in standby leave `atr_oe` at 0 and `atr_data` at 1.
- R10: `atr_data` and `atr_oe` change only after the end of a card reset pulse or a falling card-clock edge. A rising card-clock edge changes neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the card clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_rst | input | 1 | Card reset pin, asynchronous |
| card_clk | input | 1 | Card clock pin, asynchronous |
| wr_busy | input | 1 | Nonvolatile write in progress, synchronous to `clk` |
| atr_data | output | 1 | Serial response bit, 1 when idle |
| atr_oe | output | 1 | High while the response is being driven |

## Verification
A pin change is captured by the first synchronizer stage on the next rising `clk` edge. It reaches the second stage one edge later, and the state register acts on the third edge. Every output is therefore settled three system cycles after a pin moves. The bench holds each pin level for six system cycles and compares on a falling `clk` edge at the end of that hold. It checks after the rising card-clock edge as well as after the falling one, so that an output which moved early is caught.

// File: rtl/atr_pkg.sv
package atr_pkg;
    localparam int PIN_RST  = 0;
    localparam int PIN_CLK  = 1;
    localparam int NUM_PINS = 2;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_ABORT,
        EV_STEP,
        EV_END
    } atr_evt_e;
endpackage

// File: rtl/atr_pin_sync.sv
module atr_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pin_in[g]};
            prev_d  = chain_q[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign lvl[g]  = chain_q[STAGES-1];
        assign fall[g] = prev_q & ~chain_q[STAGES-1];
    end
endmodule

// File: rtl/atr_seq_core.sv
module atr_seq_core
    import atr_pkg::*;
#(
    parameter int              ATR_BITS  = 32,
    parameter logic [ATR_BITS-1:0] ATR_VALUE = 32'h55AA4019
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_lvl,
    input  logic rst_fall,
    input  logic clk_lvl,
    input  logic clk_fall,
    input  logic wr_busy,
    output logic dout,
    output logic oe
);
    localparam int IDX_W = $clog2(ATR_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ATR_BITS - 1);

    typedef struct packed {
        logic             active;
        logic             ovl;
        logic [IDX_W-1:0] idx;
        logic             dout;
        logic             oe;
    } st_t;

    localparam st_t ST_RESET = '{active: 1'b0, ovl: 1'b0, idx: '0, dout: 1'b1, oe: 1'b0};

    st_t      d, q;
    atr_evt_e evt;

    always_comb begin
        d   = q;
        evt = EV_NONE;
        if (rst_lvl && clk_lvl) d.ovl = 1'b1;
        if (rst_fall) begin
            evt = (q.ovl && !wr_busy) ? EV_START : EV_ABORT;
        end else if (q.active && !rst_lvl && clk_fall) begin
            evt = (q.idx == LAST) ? EV_END : EV_STEP;
        end
        case (evt)
            EV_START: begin
                d.active = 1'b1;
                d.idx    = '0;
                d.ovl    = 1'b0;
            end
            EV_ABORT, EV_END: begin
                d.active = 1'b0;
                d.idx    = '0;
                d.ovl    = 1'b0;
            end
            EV_STEP:  d.idx = q.idx + IDX_W'(1);
            default:  ;
        endcase
        d.oe   = d.active;
        d.dout = d.active ? ATR_VALUE[d.idx] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RESET;
        else        q <= d;
    end

    assign dout = q.dout;
    assign oe   = q.oe;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fall && q.ovl && !wr_busy |=> oe && q.idx == '0);
    assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fall && wr_busy |=> !oe);
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fall && !q.ovl |=> !oe && dout);
    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.active && !rst_lvl && !rst_fall && clk_fall && q.idx != LAST
        |=> oe && q.idx == $past(q.idx) + IDX_W'(1));
    assert_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.active && !rst_lvl && !rst_fall && clk_fall && q.idx == LAST |=> !oe);
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_fall && !clk_fall |=> $stable(dout) && $stable(oe));
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
    import atr_pkg::*;
#(
    parameter int                  ATR_BITS    = 32,
    parameter logic [ATR_BITS-1:0] ATR_VALUE   = 32'h55AA4019,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_rst,
    input  logic card_clk,
    input  logic wr_busy,
    output logic atr_data,
    output logic atr_oe
);
    logic [NUM_PINS-1:0] pins, pin_lvl, pin_fall;

    always_comb begin
        pins          = '0;
        pins[PIN_RST] = card_rst;
        pins[PIN_CLK] = card_clk;
    end

    atr_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pins),
        .lvl    (pin_lvl),
        .fall   (pin_fall)
    );

    atr_seq_core #(.ATR_BITS(ATR_BITS), .ATR_VALUE(ATR_VALUE)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_lvl  (pin_lvl[PIN_RST]),
        .rst_fall (pin_fall[PIN_RST]),
        .clk_lvl  (pin_lvl[PIN_CLK]),
        .clk_fall (pin_fall[PIN_CLK]),
        .wr_busy  (wr_busy),
        .dout     (atr_data),
        .oe       (atr_oe)
    );
endmodule

// File: tb/atr_serializer_tb.sv
module atr_serializer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic card_clk = 1'b0;
    logic wr_busy = 1'b0;
    logic atr_data, atr_oe;

    always #10 clk = ~clk;

    atr_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
        .wr_busy(wr_busy), .atr_data(atr_data), .atr_oe(atr_oe)
    );

    typedef struct {
        logic  oe;
        logic  d;
        string tag;
    } item_t;

    item_t sb[$];
    event  sample_ev;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    logic [7:0] exp_bytes [4] = '{8'h19, 8'h40, 8'hAA, 8'h55};
    bit m_active = 1'b0;
    int m_idx = 0;

    function automatic logic exp_bit(int n);
        return exp_bytes[n / 8][n % 8];
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_now(string tag);
        item_t it;
        it.oe  = m_active;
        it.d   = m_active ? exp_bit(m_idx) : 1'b1;
        it.tag = tag;
        sb.push_back(it);
        -> sample_ev;
    endtask

    task automatic rst_with_clk(string tag);
        card_rst = 1'b1; settle();
        card_clk = 1'b1; settle();
        card_clk = 1'b0; settle();
        card_rst = 1'b0; settle();
        if (!wr_busy) begin m_active = 1'b1; m_idx = 0; end
        else m_active = 1'b0;
        expect_now(tag);
    endtask

    task automatic rst_alone(string tag);
        card_rst = 1'b1; settle();
        card_rst = 1'b0; settle();
        m_active = 1'b0;
        expect_now(tag);
    endtask

    task automatic clk_pulse(string tag, bit check_rise);
        card_clk = 1'b1; settle();
        if (check_rise) expect_now({tag, " R10 rise"});
        card_clk = 1'b0; settle();
        if (m_active) begin
            if (m_idx == 31) begin m_active = 1'b0; m_idx = 0; end
            else m_idx++;
        end
        expect_now(tag);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                it = sb.pop_front();
                total++;
                if (atr_oe !== it.oe || atr_data !== it.d) begin
                    bad++;
                    $display("FAIL %s: oe=%b data=%b expected oe=%b data=%b",
                             it.tag, atr_oe, atr_data, it.oe, it.d);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_now("R1 reset state");

        for (int i = 0; i < 3; i++) clk_pulse("R9 idle clock", 1'b1);
        rst_alone("R7 reset alone while idle");

        rst_with_clk("R2 start");
        for (int i = 0; i < 32; i++) clk_pulse("R3 R4 stream bit", i < 4);
        expect_now("R5 standby after 32 bits");
        clk_pulse("R5 R9 clock after end", 1'b0);

        rst_with_clk("R2 second start");
        for (int i = 0; i < 10; i++) clk_pulse("R4 step", 1'b0);
        rst_with_clk("R6 restart from bit 0");
        for (int i = 0; i < 5; i++) clk_pulse("R6 R3 after restart", 1'b0);

        rst_alone("R7 abort mid stream");
        clk_pulse("R7 R9 clock after abort", 1'b1);

        wr_busy = 1'b1;
        rst_with_clk("R8 start blocked by busy");
        clk_pulse("R8 clock while blocked", 1'b0);
        wr_busy = 1'b0;
        rst_with_clk("R2 start after busy");
        clk_pulse("R4 step after busy", 1'b1);

        settle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule